// File: doc/BRIEF.md
# Control Pickup and Parameter Tracker

This block holds a set of stored 8-bit parameters, one for each front-panel control channel. Each parameter follows fresh digitized readings of its control. A control that has not yet been "picked up" moves its parameter by the change in its reading, with a small dead band and clamping at both ends. Once the control has been driven to an end of its travel and then brought back into the working range, the channel locks into absolute mode. From then on the parameter simply equals the reading.

A program load writes new parameter values and a baseline reading into every channel and returns all channels to relative tracking. A manual command forces every channel into absolute mode at once. Readings arrive one at a time as a valid strobe with a channel index and a value. Indices at or above the channel count are dropped.

Top module: `ctl_pickup_tracker`

## Requirements
- R1: After synchronous reset every parameter is 0x00, every baseline is 0x00 and the limit, absolute and moved flags of all channels are clear.
- R2: A load command, for every channel k, sets the parameter to `load_param[8k+7:8k]`, sets the baseline to `load_base[8k+7:8k]` and clears all three flags. It wins over a reading or manual command in the same cycle.
- R3: A reading for a channel in absolute mode copies the reading into that channel's parameter on the next clock edge.
- R4: A reading of 0x00 or 0xFF on a channel whose limit flag is clear sets the limit flag. The reading is then still handled as a relative reading.
- R5: A reading in 0x02..0xFD on a channel whose limit flag is set puts the channel into absolute mode and copies the reading into the parameter. Readings 0x00, 0x01, 0xFE and 0xFF stay relative.
- R6: In relative mode with the moved flag clear, a signed 8-bit delta (reading minus baseline) of magnitude 2 or less changes neither the parameter nor the baseline.
- R7: In relative mode, a delta of magnitude above 2 sets the moved flag. From the time the moved flag is set, every delta is added to the parameter and the reading becomes the baseline.
- R8: The relative addition clamps at 0x00 and 0xFF.
- R9: The manual command sets the absolute flag of every channel. A reading in the same cycle is first handled in the channel's previous mode.
- R10: A reading whose channel index is 14 or above changes no parameter and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_valid | input | 1 | A reading is present this cycle |
| rd_chan | input | 4 | Channel index of the reading |
| rd_value | input | 8 | Digitized reading |
| load_go | input | 1 | Load-program command |
| load_param | input | 112 | New parameters, channel k at bits 8k+7:8k |
| load_base | input | 112 | Baseline readings, channel k at bits 8k+7:8k |
| manual_go | input | 1 | Force all channels to absolute mode |
| param_out | output | 112 | Current parameters, channel k at bits 8k+7:8k |
| limit_flags | output | 14 | Per-channel limit-reached flag |
| abs_flags | output | 14 | Per-channel absolute-mode flag |
| moved_flags | output | 14 | Per-channel has-moved flag |

## Verification
A reading can fall in the same cycle as a load or a manual command. The bench provokes both cases by raising the command and the strobe on the same clock edge. For load with a reading, the result must show the loaded parameter with all flags clear. A follow-up reading within the dead band must then leave the parameter unchanged, which shows the loaded baseline was installed and not the reading. For manual with a reading on a relative, already-moved channel, the reading must be applied as a delta and every absolute flag must be set afterwards. A later reading must then be copied straight through.

// File: rtl/pickup_pkg.sv
// Shared types for the control pickup tracker.
// Assumes 8-bit readings and parameters throughout.
package pickup_pkg;
    localparam int VAL_W = 8;

    // One channel's complete tracking state
    typedef struct packed {
        logic             lim;    // end of travel seen since load
        logic             absm;   // reading drives parameter directly
        logic             moved;  // control left the dead band
        logic [VAL_W-1:0] last;   // last accepted reading (baseline)
        logic [VAL_W-1:0] param;  // stored parameter
    } ch_state_t;
endpackage

// File: rtl/pickup_sat_add.sv
// Adds a signed delta to an unsigned value and clamps the result
// to the unsigned range 0 .. 2**W-1. Purely combinational.
module pickup_sat_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] delta,     // two's complement
    output logic [W-1:0] sum_val
);
    localparam int SW = W + 2;

    logic [SW-1:0] wide;

    // Sign-extend, add, then clamp on underflow or overflow
    always_comb begin
        wide = {2'b00, base_val} + {{2{delta[W-1]}}, delta};
        if (wide[SW-1])
            sum_val = '0;
        else if (wide[W])
            sum_val = '1;
        else
            sum_val = wide[W-1:0];
    end
endmodule

// File: rtl/pickup_step.sv
// Next-state function of one channel for one accepted reading.
// Handles absolute copy, limit detection, pickup into absolute mode,
// dead band and saturating relative update. Combinational only.
module pickup_step
    import pickup_pkg::*;
#(
    parameter int DEADBAND = 2,
    parameter int EDGE_GAP = 2
) (
    input  ch_state_t        cur,
    input  logic [VAL_W-1:0] rd,
    output ch_state_t        nxt
);
    localparam logic [VAL_W-1:0] FULL  = {VAL_W{1'b1}};
    localparam logic [VAL_W-1:0] MID_L = VAL_W'(EDGE_GAP);
    localparam logic [VAL_W-1:0] MID_H = FULL - VAL_W'(EDGE_GAP);
    localparam logic [VAL_W-1:0] DBAND = VAL_W'(DEADBAND);

    logic             at_end;
    logic             in_mid;
    logic [VAL_W-1:0] delta;
    logic [VAL_W-1:0] mag;
    logic [VAL_W-1:0] rel_sum;

    // Classify the reading and measure its change from the baseline
    always_comb begin
        at_end = (rd == '0) || (rd == FULL);
        in_mid = (rd >= MID_L) && (rd <= MID_H);
        delta  = rd - cur.last;
        mag    = delta[VAL_W-1] ? (~delta + 1'b1) : delta;
    end

    pickup_sat_add #(.W(VAL_W)) u_sat (
        .base_val (cur.param),
        .delta    (delta),
        .sum_val  (rel_sum)
    );

    // Choose between absolute copy, pickup and relative update
    always_comb begin
        nxt = cur;
        if (cur.absm) begin
            nxt.param = rd;
        end else if (cur.lim && in_mid) begin
            nxt.absm  = 1'b1;
            nxt.param = rd;
        end else begin
            if (!cur.lim && at_end)
                nxt.lim = 1'b1;
            if (cur.moved || (mag > DBAND)) begin
                nxt.moved = 1'b1;
                nxt.param = rel_sum;
                nxt.last  = rd;
            end
        end
    end
endmodule

// File: rtl/pickup_slot.sv
// State register of one channel. Priority: load, then the reading
// (evaluated in the old mode), then manual forcing absolute mode.
module pickup_slot
    import pickup_pkg::*;
#(
    parameter int DEADBAND = 2,
    parameter int EDGE_GAP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [VAL_W-1:0] rd,
    input  logic             load_go,
    input  logic [VAL_W-1:0] ld_param,
    input  logic [VAL_W-1:0] ld_base,
    input  logic             manual_go,
    output ch_state_t        st
);
    ch_state_t stepped;
    ch_state_t merged;

    pickup_step #(.DEADBAND(DEADBAND), .EDGE_GAP(EDGE_GAP)) u_step (
        .cur (st),
        .rd  (rd),
        .nxt (stepped)
    );

    // Combine the reading result with the manual command
    always_comb begin
        merged = hit ? stepped : st;
        if (manual_go)
            merged.absm = 1'b1;
    end

    // Hold the channel state; load overrides everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else if (load_go) begin
            st <= '{lim: 1'b0, absm: 1'b0, moved: 1'b0,
                    last: ld_base, param: ld_param};
        end else begin
            st <= merged;
        end
    end
endmodule

// File: rtl/ctl_pickup_tracker.sv
// Top of the control pickup tracker: decodes the reading index to a
// channel, holds one state slot per channel and flattens the results.
// Assumes at most one reading per cycle; out-of-range indices hit nothing.
module ctl_pickup_tracker
    import pickup_pkg::*;
#(
    parameter int NCH      = 14,
    parameter int DEADBAND = 2,
    parameter int EDGE_GAP = 2,
    localparam int W       = VAL_W,
    localparam int CW      = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic [CW-1:0]    rd_chan,
    input  logic [W-1:0]     rd_value,
    input  logic             load_go,
    input  logic [NCH*W-1:0] load_param,
    input  logic [NCH*W-1:0] load_base,
    input  logic             manual_go,
    output logic [NCH*W-1:0] param_out,
    output logic [NCH-1:0]   limit_flags,
    output logic [NCH-1:0]   abs_flags,
    output logic [NCH-1:0]   moved_flags
);
    ch_state_t slot_st [NCH];
    logic [NCH-1:0] hit;

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        // Route the strobe only to the addressed channel
        assign hit[k] = rd_valid && (rd_chan == CW'(k));

        pickup_slot #(.DEADBAND(DEADBAND), .EDGE_GAP(EDGE_GAP)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (hit[k]),
            .rd        (rd_value),
            .load_go   (load_go),
            .ld_param  (load_param[k*W +: W]),
            .ld_base   (load_base[k*W +: W]),
            .manual_go (manual_go),
            .st        (slot_st[k])
        );

        // Flatten the slot state onto the output buses
        assign param_out[k*W +: W] = slot_st[k].param;
        assign limit_flags[k]      = slot_st[k].lim;
        assign abs_flags[k]        = slot_st[k].absm;
        assign moved_flags[k]      = slot_st[k].moved;
    end
endmodule

// File: rtl/pickup_tracker_chk.sv
// Assertion checker for the control pickup tracker, attached by bind.
module pickup_tracker_chk #(
    parameter int NCH = 14,
    parameter int W   = 8,
    parameter int CW  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic [CW-1:0]    rd_chan,
    input logic [W-1:0]     rd_value,
    input logic             load_go,
    input logic [NCH*W-1:0] load_param,
    input logic             manual_go,
    input logic [NCH*W-1:0] param_out,
    input logic [NCH-1:0]   limit_flags,
    input logic [NCH-1:0]   abs_flags,
    input logic [NCH-1:0]   moved_flags
);
    logic was_rst;

    // Remember that the previous edge saw reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1
    always @(posedge clk) begin
        if (rst_n && was_rst) begin
            reset_clear_chk: assert (param_out == '0 && limit_flags == '0 &&
                                     abs_flags == '0 && moved_flags == '0);
        end
    end

    // R2
    load_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> (param_out == $past(load_param)) && (limit_flags == '0)
                    && (abs_flags == '0) && (moved_flags == '0));

    // R9
    manual_all_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (manual_go && !load_go) |=> (&abs_flags));

    // R10
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && (int'(rd_chan) >= NCH) && !load_go && !manual_go)
        |=> $stable(param_out) && $stable(limit_flags) && $stable(abs_flags)
            && $stable(moved_flags));

    // R4
    limit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_go |=> ((limit_flags & $past(limit_flags)) == $past(limit_flags)));

    for (genvar k = 0; k < NCH; k++) begin : g_chk
        // R3
        abs_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && (rd_chan == CW'(k)) && abs_flags[k] && !load_go)
            |=> (param_out[k*W +: W] == $past(rd_value)));
    end
endmodule

bind ctl_pickup_tracker pickup_tracker_chk #(.NCH(NCH), .W(W), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid    (rd_valid),
    .rd_chan     (rd_chan),
    .rd_value    (rd_value),
    .load_go     (load_go),
    .load_param  (load_param),
    .manual_go   (manual_go),
    .param_out   (param_out),
    .limit_flags (limit_flags),
    .abs_flags   (abs_flags),
    .moved_flags (moved_flags)
);

// File: tb/ctl_pickup_tracker_tb.sv
`timescale 1ns/1ps
module ctl_pickup_tracker_tb;
    localparam int NCH = 14;
    localparam int W   = 8;
    localparam int CW  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_valid = 1'b0;
    logic [CW-1:0]    rd_chan = '0;
    logic [W-1:0]     rd_value = '0;
    logic             load_go = 1'b0;
    logic [NCH*W-1:0] load_param = '0;
    logic [NCH*W-1:0] load_base = '0;
    logic             manual_go = 1'b0;
    logic [NCH*W-1:0] param_out;
    logic [NCH-1:0]   limit_flags, abs_flags, moved_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ctl_pickup_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_chan(rd_chan),
        .rd_value(rd_value), .load_go(load_go), .load_param(load_param),
        .load_base(load_base), .manual_go(manual_go), .param_out(param_out),
        .limit_flags(limit_flags), .abs_flags(abs_flags), .moved_flags(moved_flags)
    );

    // Row: {req[3:0], chan[3:0], reading[7:0], exp_param[7:0], exp {lim,abs,moved}}
    localparam int NV = 17;
    localparam logic [26:0] VEC [NV] = '{
        {4'd6, 4'd3, 8'h41, 8'h80, 3'b000},  // R6 delta +1
        {4'd6, 4'd3, 8'h42, 8'h80, 3'b000},  // R6 delta +2
        {4'd6, 4'd3, 8'h3E, 8'h80, 3'b000},  // R6 delta -2
        {4'd7, 4'd3, 8'h43, 8'h83, 3'b001},  // R7 delta +3 picks up
        {4'd7, 4'd3, 8'h44, 8'h84, 3'b001},  // R7 small delta after moved
        {4'd7, 4'd3, 8'h30, 8'h70, 3'b001},  // R7 negative delta
        {4'd4, 4'd3, 8'hFF, 8'h3F, 3'b101},  // R4 top end, still relative
        {4'd5, 4'd3, 8'hFE, 8'h3E, 3'b101},  // R5 0xFE stays relative
        {4'd5, 4'd3, 8'h01, 8'h41, 3'b101},  // R5 0x01 stays relative
        {4'd5, 4'd3, 8'h80, 8'h80, 3'b111},  // R5 enters absolute
        {4'd3, 4'd3, 8'h10, 8'h10, 3'b111},  // R3 absolute copy
        {4'd8, 4'd5, 8'h60, 8'hFF, 3'b001},  // R8 clamp high
        {4'd8, 4'd6, 8'h20, 8'h00, 3'b001},  // R8 clamp low
        {4'd4, 4'd5, 8'h00, 8'h9F, 3'b101},  // R4 bottom end
        {4'd5, 4'd5, 8'h02, 8'h02, 3'b111},  // R5 lower edge of range
        {4'd4, 4'd7, 8'hFF, 8'h22, 3'b100},  // R4 limit even inside dead band
        {4'd5, 4'd7, 8'hFD, 8'hFD, 3'b110}   // R5 upper edge of range
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pv(input int c);
        return int'(param_out[c*W +: W]);
    endfunction

    function automatic int fl(input int c);
        return int'({limit_flags[c], abs_flags[c], moved_flags[c]});
    endfunction

    task automatic do_read(input int c, input int v);
        @(negedge clk);
        rd_valid = 1'b1; rd_chan = CW'(c); rd_value = W'(v);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic do_load(input logic [NCH*W-1:0] p, input logic [NCH*W-1:0] b);
        @(negedge clk);
        load_go = 1'b1; load_param = p; load_base = b;
        @(negedge clk);
        load_go = 1'b0;
    endtask

    initial begin
        logic [NCH*W-1:0] lp, lb, snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 params after reset", (param_out == '0) ? 1 : 0, 1);
        chk("R1 flags after reset", int'(limit_flags | abs_flags | moved_flags), 0);
        rst_n = 1'b1;

        // R2 load: ch3 80/40, ch5 F0/10, ch6 05/80, ch7 22/00
        lp = '0; lb = '0;
        lp[3*W +: W] = 8'h80; lb[3*W +: W] = 8'h40;
        lp[5*W +: W] = 8'hF0; lb[5*W +: W] = 8'h10;
        lp[6*W +: W] = 8'h05; lb[6*W +: W] = 8'h80;
        lp[7*W +: W] = 8'h22; lb[7*W +: W] = 8'h00;
        do_load(lp, lb);
        chk("R2 loaded params", (param_out == lp) ? 1 : 0, 1);
        chk("R2 flags cleared", int'(limit_flags | abs_flags | moved_flags), 0);

        for (int i = 0; i < NV; i++) begin
            do_read(int'(VEC[i][22:19]), int'(VEC[i][18:11]));
            chk($sformatf("R%0d vector %0d param", VEC[i][26:23], i),
                pv(int'(VEC[i][22:19])), int'(VEC[i][10:3]));
            chk($sformatf("R%0d vector %0d flags", VEC[i][26:23], i),
                fl(int'(VEC[i][22:19])), int'(VEC[i][2:0]));
        end

        // R10 indices 14 and 15 touch nothing
        snap = param_out;
        do_read(14, 8'h00);
        do_read(15, 8'h55);
        chk("R10 params unchanged", (param_out == snap) ? 1 : 0, 1);
        chk("R10 limit flags unchanged", int'(limit_flags), int'(14'b00_0000_1010_1000));

        // R2 load beats a same-cycle reading; baseline comes from load
        lp = '0; lb = '0;
        lp[3*W +: W] = 8'h11; lb[3*W +: W] = 8'h50;
        @(negedge clk);
        load_go = 1'b1; load_param = lp; load_base = lb;
        rd_valid = 1'b1; rd_chan = 4'd3; rd_value = 8'h99;
        @(negedge clk);
        load_go = 1'b0; rd_valid = 1'b0;
        chk("R2 load over reading param", pv(3), 8'h11);
        chk("R2 load over reading flags", fl(3), 0);
        do_read(3, 8'h52);
        chk("R2 baseline installed (dead band)", pv(3), 8'h11);
        do_read(3, 8'h54);
        chk("R7 move from loaded baseline", pv(3), 8'h15);

        // R9 manual with a same-cycle relative reading
        @(negedge clk);
        manual_go = 1'b1; rd_valid = 1'b1; rd_chan = 4'd3; rd_value = 8'h56;
        @(negedge clk);
        manual_go = 1'b0; rd_valid = 1'b0;
        chk("R9 reading applied in old mode", pv(3), 8'h17);
        chk("R9 all channels absolute", int'(abs_flags), (1 << NCH) - 1);
        do_read(0, 8'h33);
        chk("R3 copy after manual", pv(0), 8'h33);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 params after mid-run reset", (param_out == '0) ? 1 : 0, 1);
        chk("R1 flags after mid-run reset", int'(limit_flags | abs_flags | moved_flags), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule